// File: doc/BRIEF.md
# First Register-Write Position Scanner

This block watches a stream of 32-bit instruction words and finds the first one that writes a chosen register. A client pulses `start` with a register number. It then presents the program one word per accepted cycle, with `word_last` marking the final word. One cycle after that final word, the block pulses `done`. At the same time it shows whether a writer was seen (`found`) and the zero-based position of the earliest writer (`index`).

Whether a word writes a register depends on its operation code. System calls also depend on their extension value. The destination is always the first register field. The program counter register can never be a destination, so it never matches. Streams longer than the address space of the machine give a not-found result. So does a register number outside the register file. The block does not check whether a word is a legal instruction.

Top module: `first_write_scan`

## Requirements
- R1: After reset, `done` and `found` are low and `index` is zero.
- R2: The operation code is bits [31:27] and the destination register is bits [23:21]. Codes 0-15 and 22-24 always write the destination register. No other field of the word affects the result.
- R3: Compare-and-branch codes 16-21 and the store code 25 never write a register.
- R4: System-call code 26 writes its destination only when the extension field, bits [26:24], holds 0 or 2. Extension values 1, 3, 4 and above do not write.
- R5: Codes 27-31 are treated as not writing a register.
- R6: `index` reports the zero-based position of the earliest writer. Later writers in the same stream do not change the result.
- R7: A target of 6 (the program counter) or 7 always gives not-found. The stream is still consumed up to its last word.
- R8: A stream of more than MAX_WORDS (8192) words gives not-found, even if a writer came early. A stream of exactly 8192 words can report index 8191.
- R9: `done` is high for exactly one cycle, in the cycle after the clock edge that accepts the last word. `found` and `index` hold their value from that cycle until the next `start`. `index` is 0 whenever `found` is low.
- R10: `start` aborts any scan in progress and begins a new one. A word presented in the same cycle as `start` is not counted.
- R11: Words presented while no scan is active are ignored and produce no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan; captures `target_reg` |
| target_reg | input | 3 | Register number to search for |
| word_valid | input | 1 | `word_data` carries a program word this cycle |
| word_data | input | 32 | Instruction word |
| word_last | input | 1 | Final word of the stream (qualified by `word_valid`) |
| done | output | 1 | One-cycle pulse: result is ready |
| found | output | 1 | A writer of the target was seen |
| index | output | 13 | Position of the earliest writer, 0 when not found |

## Verification
Two events can land in the same cycle: the first matching word and the end of the stream. The bench sends streams whose only writer is the final word, including a one-word stream. It expects `found` with that word's position in the very next cycle. It also provokes a clash between the length limit and an earlier match. A writer at position 5 in an 8193-word stream must be reported as not-found. An 8192-word stream whose only writer is the final word must report index 8191.

// File: rtl/fws_pkg.sv
package fws_pkg;
    localparam int WORD_W  = 32;
    localparam int OPC_W   = 5;
    localparam int EXT_W   = 3;
    localparam int REG_W   = 3;

    localparam int OPC_LSB = 27;
    localparam int EXT_LSB = 24;
    localparam int DST_LSB = 21;

    localparam logic [OPC_W-1:0] OP_BR_FIRST = 5'd16;
    localparam logic [OPC_W-1:0] OP_BR_LAST  = 5'd21;
    localparam logic [OPC_W-1:0] OP_STORE    = 5'd25;
    localparam logic [OPC_W-1:0] OP_SYSCALL  = 5'd26;
    localparam logic [OPC_W-1:0] OP_TOP      = 5'd26;

    localparam logic [EXT_W-1:0] SC_READ_NUM = 3'd0;
    localparam logic [EXT_W-1:0] SC_READ_CHR = 3'd2;

    typedef enum logic {
        PH_IDLE,
        PH_SCAN
    } phase_e;
endpackage

// File: rtl/fws_dest_decode.sv
module fws_dest_decode
    import fws_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int PC_REG   = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic [REG_W-1:0]  target,
    output logic              hit
);
    logic [OPC_W-1:0]    opc;
    logic [EXT_W-1:0]    ext;
    logic [REG_W-1:0]    dst;
    logic                writes;
    logic [NUM_REGS-1:0] dst_vec;

    always_comb begin
        opc = word[OPC_LSB +: OPC_W];
        ext = word[EXT_LSB +: EXT_W];
        dst = word[DST_LSB +: REG_W];
    end

    // operation class decides whether the first register field is written
    always_comb begin
        if (opc > OP_TOP) begin
            writes = 1'b0;
        end else if (opc >= OP_BR_FIRST && opc <= OP_BR_LAST) begin
            writes = 1'b0;
        end else if (opc == OP_STORE) begin
            writes = 1'b0;
        end else if (opc == OP_SYSCALL) begin
            writes = (ext == SC_READ_NUM) || (ext == SC_READ_CHR);
        end else begin
            writes = 1'b1;
        end
    end

    // one-hot destination vector; the program counter slot is tied low
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_dst
        if (r == PC_REG) begin : g_pc
            assign dst_vec[r] = 1'b0;
        end else begin : g_gp
            assign dst_vec[r] = writes && (dst == REG_W'(r));
        end
    end

    always_comb begin
        hit = 1'b0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (target == REG_W'(r)) begin
                hit = dst_vec[r];
            end
        end
    end
endmodule

// File: rtl/fws_pos_counter.sv
module fws_pos_counter #(
    parameter int MAX_WORDS = 8192,
    parameter int IDX_W     = $clog2(MAX_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] pos,
    output logic             spill,
    output logic             ovf_q
);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             ovf;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        spill = advance && (cnt_q.count == CNT_W'(MAX_WORDS));
        if (clear) begin
            cnt_d.count = '0;
            cnt_d.ovf   = 1'b0;
        end else if (advance) begin
            if (spill) begin
                cnt_d.ovf = 1'b1;
            end else begin
                cnt_d.count = cnt_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pos   = cnt_q.count[IDX_W-1:0];
    assign ovf_q = cnt_q.ovf;
endmodule

// File: rtl/first_write_scan.sv
module first_write_scan
    import fws_pkg::*;
#(
    parameter int MAX_WORDS = 8192,
    parameter int NUM_REGS  = 7,
    parameter int PC_REG    = 6,
    localparam int IDX_W    = $clog2(MAX_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  target_reg,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_last,
    output logic              done,
    output logic              found,
    output logic [IDX_W-1:0]  index
);
    typedef struct packed {
        phase_e           phase;
        logic [REG_W-1:0] target;
        logic             seen;
        logic [IDX_W-1:0] seen_idx;
        logic             done;
        logic             res_found;
        logic [IDX_W-1:0] res_idx;
    } scan_t;

    scan_t st_d, st_q;

    logic             accept;
    logic             word_hit;
    logic             new_hit;
    logic [IDX_W-1:0] pos;
    logic             spill;
    logic             ovf_q;

    fws_dest_decode #(
        .NUM_REGS (NUM_REGS),
        .PC_REG   (PC_REG)
    ) u_decode (
        .word   (word_data),
        .target (st_q.target),
        .hit    (word_hit)
    );

    fws_pos_counter #(
        .MAX_WORDS (MAX_WORDS),
        .IDX_W     (IDX_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .advance (accept),
        .pos     (pos),
        .spill   (spill),
        .ovf_q   (ovf_q)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = (st_q.phase == PH_SCAN) && word_valid && !start;
        new_hit   = accept && word_hit && !st_q.seen && !spill && !ovf_q;

        if (start) begin
            st_d.phase     = PH_SCAN;
            st_d.target    = target_reg;
            st_d.seen      = 1'b0;
            st_d.seen_idx  = '0;
            st_d.res_found = 1'b0;
            st_d.res_idx   = '0;
        end else if (accept) begin
            if (new_hit) begin
                st_d.seen     = 1'b1;
                st_d.seen_idx = pos;
            end
            if (word_last) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                if ((st_q.seen || new_hit) && !(ovf_q || spill)) begin
                    st_d.res_found = 1'b1;
                    st_d.res_idx   = st_q.seen ? st_q.seen_idx : pos;
                end else begin
                    st_d.res_found = 1'b0;
                    st_d.res_idx   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done  = st_q.done;
    assign found = st_q.res_found;
    assign index = st_q.res_idx;
endmodule

// File: rtl/first_write_scan_chk.sv
module first_write_scan_chk #(
    parameter int MAX_WORDS = 8192,
    parameter int NUM_REGS  = 7,
    parameter int PC_REG    = 6,
    parameter int IDX_W     = $clog2(MAX_WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [2:0]       target_reg,
    input logic             word_valid,
    input logic             word_last,
    input logic             done,
    input logic             found,
    input logic [IDX_W-1:0] index
);
    localparam int CW = $clog2(MAX_WORDS + 2);

    logic          busy;
    logic [2:0]    tgt;
    logic [CW-1:0] seen_words;
    logic          took_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            tgt        <= '0;
            seen_words <= '0;
            took_last  <= 1'b0;
        end else begin
            took_last <= busy && word_valid && word_last && !start;
            if (start) begin
                busy       <= 1'b1;
                tgt        <= target_reg;
                seen_words <= '0;
            end else if (busy && word_valid) begin
                if (seen_words <= CW'(MAX_WORDS)) begin
                    seen_words <= seen_words + 1'b1;
                end
                if (word_last) begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9 R11
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> took_last);

    // R9
    miss_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (index == '0));

    // R9
    found_rises_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> done);

    // R7
    bad_target_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (tgt != 3'(PC_REG) && int'(tgt) < NUM_REGS));

    // R8
    long_stream_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (seen_words <= CW'(MAX_WORDS)));

    // R6
    index_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (CW'(index) < seen_words));
endmodule

bind first_write_scan first_write_scan_chk #(
    .MAX_WORDS (MAX_WORDS),
    .NUM_REGS  (NUM_REGS),
    .PC_REG    (PC_REG),
    .IDX_W     (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .target_reg (target_reg),
    .word_valid (word_valid),
    .word_last  (word_last),
    .done       (done),
    .found      (found),
    .index      (index)
);

// File: tb/tb_first_write_scan.sv
module tb_first_write_scan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  target_reg = '0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_last = 1'b0;
    logic        done;
    logic        found;
    logic [12:0] index;

    int tests = 0;
    int fails = 0;
    logic [31:0] prog [0:15];

    always #4 clk = ~clk;

    first_write_scan dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .target_reg (target_reg),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_last  (word_last),
        .done       (done),
        .found      (found),
        .index      (index)
    );

    function automatic logic [31:0] mk(input int op, input int ext, input int r1);
        return {5'(op), 3'(ext), 3'(r1), 21'h1F5A3};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic begin_scan(input logic [2:0] tr);
        @(negedge clk);
        start      = 1'b1;
        target_reg = tr;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w, input bit last);
        word_valid = 1'b1;
        word_data  = w;
        word_last  = last;
        @(negedge clk);
        word_valid = 1'b0;
        word_last  = 1'b0;
    endtask

    task automatic judge(input string tag, input bit ef, input int ei);
        chk({tag, " done"}, int'(done), 1);
        chk({tag, " found"}, int'(found), int'(ef));
        chk({tag, " index"}, int'(index), ef ? ei : 0);
        @(negedge clk);
        chk({tag, " R9 done pulse"}, int'(done), 0);
        chk({tag, " R9 found held"}, int'(found), int'(ef));
    endtask

    task automatic run_prog(input string tag, input logic [2:0] tr, input int n,
                            input bit ef, input int ei);
        begin_scan(tr);
        for (int i = 0; i < n; i++) begin
            put_word(prog[i], i == n - 1);
        end
        judge(tag, ef, ei);
    endtask

    task automatic run_long(input string tag, input int n, input int hit_at,
                            input bit ef, input int ei);
        begin_scan(3'd2);
        for (int i = 0; i < n; i++) begin
            put_word((i == hit_at) ? mk(0, 0, 2) : mk(25, 0, 2), i == n - 1);
        end
        judge(tag, ef, ei);
    endtask

    task automatic t_reset();
        chk("R1 done", int'(done), 0);
        chk("R1 found", int'(found), 0);
        chk("R1 index", int'(index), 0);
    endtask

    task automatic t_classes();
        // R3: branch and store never write; R2: arithmetic writes
        prog[0] = mk(25, 0, 3);
        prog[1] = mk(16, 0, 3);
        prog[2] = mk(21, 0, 3);
        prog[3] = mk(9, 0, 3);
        run_prog("R2 R3 class", 3'd3, 4, 1'b1, 3);
        for (int op = 16; op <= 21; op++) prog[op - 16] = mk(op, 0, 4);
        prog[6] = mk(25, 0, 4);
        run_prog("R3 no writers", 3'd4, 7, 1'b0, 0);
        prog[0] = mk(22, 0, 5);
        prog[1] = mk(24, 0, 5);
        run_prog("R2 move", 3'd5, 2, 1'b1, 0);
        prog[0] = {5'd16, 3'd0, 3'd1, 3'd0, 3'd0, 15'd0};
        prog[1] = {5'd0, 3'd5, 3'd3, 3'd0, 3'd0, 15'h7FFF};
        prog[2] = {5'd0, 3'd0, 3'd0, 3'd0, 3'd0, 15'd0};
        run_prog("R2 other fields", 3'd0, 3, 1'b1, 2);
    endtask

    task automatic t_sys();
        prog[0] = mk(26, 1, 1);
        prog[1] = mk(26, 3, 1);
        prog[2] = mk(26, 4, 1);
        prog[3] = mk(26, 7, 1);
        prog[4] = mk(26, 2, 1);
        run_prog("R4 sys ext2", 3'd1, 5, 1'b1, 4);
        prog[0] = mk(26, 0, 2);
        run_prog("R4 sys ext0", 3'd2, 1, 1'b1, 0);
        prog[0] = mk(26, 5, 2);
        prog[1] = mk(26, 6, 2);
        run_prog("R4 sys high ext", 3'd2, 2, 1'b0, 0);
    endtask

    task automatic t_bad_opc();
        for (int op = 27; op <= 31; op++) prog[op - 27] = mk(op, 0, 0);
        run_prog("R5 codes 27-31", 3'd0, 5, 1'b0, 0);
    endtask

    task automatic t_earliest();
        prog[0] = mk(25, 0, 4);
        prog[1] = mk(24, 0, 4);
        prog[2] = mk(1, 0, 3);
        prog[3] = mk(22, 0, 4);
        prog[4] = mk(2, 0, 4);
        run_prog("R6 earliest", 3'd4, 5, 1'b1, 1);
    endtask

    task automatic t_bad_target();
        prog[0] = mk(0, 0, 6);
        prog[1] = mk(24, 0, 6);
        prog[2] = mk(26, 0, 6);
        run_prog("R7 target 6", 3'd6, 3, 1'b0, 0);
        prog[0] = mk(0, 0, 7);
        prog[1] = mk(26, 2, 7);
        run_prog("R7 target 7", 3'd7, 2, 1'b0, 0);
    endtask

    task automatic t_last_word_hit();
        // R9: match and end of stream in one cycle, timing checked
        prog[0] = mk(23, 0, 0);
        run_prog("R9 single word", 3'd0, 1, 1'b1, 0);
        prog[0] = mk(25, 0, 5);
        prog[1] = mk(16, 0, 5);
        prog[2] = mk(11, 0, 5);
        run_prog("R9 hit on last", 3'd5, 3, 1'b1, 2);
    endtask

    task automatic t_long();
        run_long("R8 over limit", 8193, 5, 1'b0, 0);
        run_long("R8 at limit", 8192, 8191, 1'b1, 8191);
    endtask

    task automatic t_restart();
        begin_scan(3'd1);
        put_word(mk(0, 0, 1), 1'b0);
        @(negedge clk);
        start      = 1'b1;
        target_reg = 3'd2;
        word_valid = 1'b1;
        word_data  = mk(0, 0, 2);
        word_last  = 1'b0;
        @(negedge clk);
        start      = 1'b0;
        word_valid = 1'b0;
        chk("R10 no done on restart", int'(done), 0);
        put_word(mk(25, 0, 2), 1'b0);
        put_word(mk(3, 0, 2), 1'b1);
        judge("R10 restart", 1'b1, 1);
    endtask

    task automatic t_idle_words();
        @(negedge clk);
        put_word(mk(0, 0, 3), 1'b1);
        chk("R11 idle no done", int'(done), 0);
        @(negedge clk);
        chk("R11 idle still no done", int'(done), 0);
        chk("R11 result unchanged", int'(index), 1);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_classes();
        t_sys();
        t_bad_opc();
        t_earliest();
        t_bad_target();
        t_last_word_hit();
        t_long();
        t_restart();
        t_idle_words();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule